// File: doc/BRIEF.md
# Fully Associative Translation Cache with Invalidation

This block caches recent page translations for a processor's memory path. Each entry holds a virtual page number as its tag and a cached page table entry (a physical frame number plus attribute bits) as its value. A lookup compares the requested page number against every entry at once. In the same cycle it reports a hit or a miss, the physical address (the hit entry's frame joined with the untranslated page offset) and the entry's attribute bits.

After a miss, the page walker loads a translation through the fill port. A free entry is used first. When no entry is free, a not-recently-used choice picks the victim. It relies on one referenced bit per entry, set by hits and by fills and aged all at once when the bits would saturate. Software keeps the cache consistent with the page tables in two ways. It drops one translation by page number when that page's protection changes, and it clears the whole cache with a flush on a context switch.

Top module: `tlb_assoc_cache`

## Requirements
- R1: After reset every entry is empty, so every lookup misses.
- R2: A lookup with `lk_valid` high that matches a resident page raises `lk_hit` in the same cycle, with `lk_paddr` = {stored frame, `lk_vaddr[11:0]`} and `lk_attr` = the stored attribute bits. `lk_hit` is low whenever `lk_valid` is low.
- R3: A lookup that matches no resident page gives `lk_hit` = 0, `lk_paddr` = 0 and `lk_attr` = 0.
- R4: A fill takes the lowest-index empty entry while one exists, so 16 fills of distinct pages into an empty cache leave all 16 resident.
- R5: A fill whose page is already resident overwrites that entry in place. Later lookups return the new frame and no other entry is lost.
- R6: A fill into a full cache evicts the lowest-index entry whose referenced bit is clear. A lookup hit sets the hit entry's referenced bit, and a fill sets the written entry's referenced bit.
- R7: When an update would leave every referenced bit set, only the bits set in that cycle are kept and all others are cleared. As a result, filling a 16-entry cache with no lookups and then filling once more evicts entry 0.
- R8: An invalidate removes only the entry whose page matches `inv_vpn`, and an invalidate of an absent page changes nothing. The next fill reuses the freed slot without evicting anything.
- R9: A flush empties every entry, and all later lookups miss until new fills arrive.
- R10: A flush takes priority over a fill or an invalidate in the same cycle, so the fill is dropped and its page is not resident afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Lookup found a resident translation |
| lk_paddr | output | 32 | Physical address (0 on miss) |
| lk_attr | output | 4 | Attribute bits of the hit entry (0 on miss) |
| fill_valid | input | 1 | Load a translation |
| fill_vpn | input | 20 | Virtual page number to load |
| fill_frame | input | 20 | Physical frame number to load |
| fill_attr | input | 4 | Attribute bits to load |
| inv_valid | input | 1 | Remove one translation |
| inv_vpn | input | 20 | Page number to remove |
| flush | input | 1 | Remove all translations |

## Verification
The checker watches the invariants on every cycle. No page may match two entries at once. A referenced bit never stays set on an empty entry, and the referenced bits are never all set. A flush empties the cache on the next edge even when a fill arrives with it. A miss drives zero onto the address, and no hit appears without a request. Victim order depends on hit history and on the bulk aging of the referenced bits, and an overwrite or an invalidate must leave the other entries untouched. The bench's scenarios are the only place these are shown. They fill the cache, shape the referenced bits with lookups, and then probe at the ports which page was evicted and which pages survived.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Source of the replacement choice for a fill of a new page.
    typedef enum logic [1:0] {
        VIC_FREE     = 2'd0,
        VIC_UNREF    = 2'd1,
        VIC_FALLBACK = 2'd2
    } vic_src_e;

endpackage

// File: rtl/tlb_lowest_enc.sv
module tlb_lowest_enc #(
    parameter int ENTRIES = 16,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] req,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_tag_match.sv
module tlb_tag_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20
) (
    input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
    input  logic [ENTRIES-1:0]            valid,
    input  logic [VPN_W-1:0]              vpn,
    output logic [ENTRIES-1:0]            match
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == vpn);
    end

endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] valid,
    input  logic [ENTRIES-1:0] refd,
    output logic [IDX_W-1:0]   idx,
    output vic_src_e           src
);

    logic             free_found, unref_found;
    logic [IDX_W-1:0] free_idx, unref_idx;

    tlb_lowest_enc #(.ENTRIES(ENTRIES)) u_free (
        .req   (~valid),
        .found (free_found),
        .idx   (free_idx)
    );

    tlb_lowest_enc #(.ENTRIES(ENTRIES)) u_unref (
        .req   (valid & ~refd),
        .found (unref_found),
        .idx   (unref_idx)
    );

    always_comb begin
        if (free_found) begin
            idx = free_idx;
            src = VIC_FREE;
        end else if (unref_found) begin
            idx = unref_idx;
            src = VIC_UNREF;
        end else begin
            idx = '0;
            src = VIC_FALLBACK;
        end
    end

endmodule

// File: rtl/tlb_assoc_cache.sv
module tlb_assoc_cache
    import tlb_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int ATTR_W  = 4,
    parameter int ENTRIES = 16,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int PFN_W = PA_W - OFF_W,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_paddr,
    output logic [ATTR_W-1:0] lk_attr,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_frame,
    input  logic [ATTR_W-1:0] fill_attr,
    input  logic              inv_valid,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic              flush
);

    typedef struct packed {
        logic [PFN_W-1:0]  frame;
        logic [ATTR_W-1:0] attr;
    } pte_t;

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0]            refd;
        logic [ENTRIES-1:0][VPN_W-1:0] tag;
        pte_t [ENTRIES-1:0]            pte;
    } state_t;

    state_t st_d, st_q;

    logic [VPN_W-1:0]   lk_vpn;
    logic [OFF_W-1:0]   lk_off;
    logic [ENTRIES-1:0] lk_match, fill_match, inv_match;
    logic               lk_found, fill_found;
    logic [IDX_W-1:0]   lk_idx, fill_idx, vic_idx, wr_idx;
    vic_src_e           vic_src;
    logic [ENTRIES-1:0] set_mask;
    pte_t               hit_pte;

    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
    assign lk_off = lk_vaddr[OFF_W-1:0];

    // Parallel tag compare for each request source.
    tlb_tag_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_match (
        .tags  (st_q.tag),
        .valid (st_q.valid),
        .vpn   (lk_vpn),
        .match (lk_match)
    );

    tlb_tag_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fill_match (
        .tags  (st_q.tag),
        .valid (st_q.valid),
        .vpn   (fill_vpn),
        .match (fill_match)
    );

    tlb_tag_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_inv_match (
        .tags  (st_q.tag),
        .valid (st_q.valid),
        .vpn   (inv_vpn),
        .match (inv_match)
    );

    tlb_lowest_enc #(.ENTRIES(ENTRIES)) u_lk_enc (
        .req   (lk_match),
        .found (lk_found),
        .idx   (lk_idx)
    );

    tlb_lowest_enc #(.ENTRIES(ENTRIES)) u_fill_enc (
        .req   (fill_match),
        .found (fill_found),
        .idx   (fill_idx)
    );

    tlb_victim_pick #(.ENTRIES(ENTRIES)) u_victim (
        .valid (st_q.valid),
        .refd  (st_q.refd),
        .idx   (vic_idx),
        .src   (vic_src)
    );

    // Lookup result, same cycle as the request.
    always_comb begin
        hit_pte  = st_q.pte[lk_idx];
        lk_hit   = lk_valid && lk_found;
        lk_paddr = '0;
        lk_attr  = '0;
        if (lk_hit) begin
            lk_paddr = {hit_pte.frame, lk_off};
            lk_attr  = hit_pte.attr;
        end
    end

    // Next-state computation.
    always_comb begin
        st_d     = st_q;
        set_mask = '0;
        wr_idx   = fill_found ? fill_idx : vic_idx;
        if (flush) begin
            st_d.valid = '0;
            st_d.refd  = '0;
        end else begin
            if (lk_hit) begin
                set_mask[lk_idx] = 1'b1;
            end
            if (inv_valid) begin
                st_d.valid = st_d.valid & ~inv_match;
                st_d.refd  = st_d.refd & ~inv_match;
            end
            if (fill_valid) begin
                st_d.valid[wr_idx]     = 1'b1;
                st_d.tag[wr_idx]       = fill_vpn;
                st_d.pte[wr_idx].frame = fill_frame;
                st_d.pte[wr_idx].attr  = fill_attr;
                set_mask[wr_idx]       = 1'b1;
            end
            st_d.refd = (st_d.refd | set_mask) & st_d.valid;
            if (&st_d.refd) begin
                st_d.refd = set_mask & st_d.valid;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tlb_assoc_cache_chk.sv
module tlb_assoc_cache_chk #(
    parameter int ENTRIES = 16,
    parameter int PA_W    = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic               lk_hit,
    input logic [PA_W-1:0]    lk_paddr,
    input logic               fill_valid,
    input logic               flush,
    input logic [ENTRIES-1:0] valid_q,
    input logic [ENTRIES-1:0] refd_q,
    input logic [ENTRIES-1:0] lk_match
);

    // R2
    hit_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !lk_hit);

    // R3
    miss_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_hit) |-> (lk_paddr == '0));

    // R5
    no_dup_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R7
    ref_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refd_q & ~valid_q) == '0);

    // R7
    if (ENTRIES > 2) begin : g_sat
        ref_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(&refd_q));
    end

    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));

    // R10
    flush_drops_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && fill_valid) |=> (valid_q == '0));

endmodule

bind tlb_assoc_cache tlb_assoc_cache_chk #(.ENTRIES(ENTRIES), .PA_W(PA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_hit     (lk_hit),
    .lk_paddr   (lk_paddr),
    .fill_valid (fill_valid),
    .flush      (flush),
    .valid_q    (st_q.valid),
    .refd_q     (st_q.refd),
    .lk_match   (lk_match)
);

// File: tb/tb_tlb_assoc_cache.sv
module tb_tlb_assoc_cache;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit;
    logic [31:0] lk_paddr;
    logic [3:0]  lk_attr;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_frame = '0;
    logic [3:0]  fill_attr = '0;
    logic        inv_valid = 1'b0;
    logic [19:0] inv_vpn = '0;
    logic        flush = 1'b0;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    localparam logic [19:0] BASE = 20'h01000;

    always #10 clk = ~clk;

    tlb_assoc_cache dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_attr(lk_attr),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_frame(fill_frame), .fill_attr(fill_attr),
        .inv_valid(inv_valid), .inv_vpn(inv_vpn),
        .flush(flush)
    );

    function automatic logic [19:0] frm(input logic [19:0] v);
        return v ^ 20'h5A5A5;
    endfunction

    function automatic logic [3:0] atr(input logic [19:0] v);
        return v[3:0] ^ 4'h9;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive a lookup at the falling edge, sample before the next rising edge,
    // leave the request up across that edge so a hit updates the referenced bit.
    task automatic probe(input logic [19:0] vpn, input bit exp_hit,
                         input logic [19:0] exp_frame, input logic [3:0] exp_attr,
                         input string req);
        logic [11:0] off;
        logic [31:0] exp_pa;
        off = vpn[11:0] ^ 12'h3C7;
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vaddr = {vpn, off};
        #2;
        exp_pa = exp_hit ? {exp_frame, off} : 32'h0;
        chk(lk_hit == exp_hit, req, 64'(lk_hit), 64'(exp_hit));
        chk(lk_paddr == exp_pa, req, 64'(lk_paddr), 64'(exp_pa));
        chk(lk_attr == (exp_hit ? exp_attr : 4'h0), req, 64'(lk_attr),
            64'(exp_hit ? exp_attr : 4'h0));
        @(posedge clk);
        #1 lk_valid = 1'b0;
    endtask

    task automatic hit_std(input logic [19:0] vpn, input string req);
        probe(vpn, 1'b1, frm(vpn), atr(vpn), req);
    endtask

    task automatic miss(input logic [19:0] vpn, input string req);
        probe(vpn, 1'b0, 20'h0, 4'h0, req);
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] frame,
                        input logic [3:0] a, input bit with_flush);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_vpn   = vpn;
        fill_frame = frame;
        fill_attr  = a;
        flush      = with_flush;
        @(negedge clk);
        fill_valid = 1'b0;
        flush      = 1'b0;
    endtask

    task automatic fill_std(input logic [19:0] vpn);
        fill(vpn, frm(vpn), atr(vpn), 1'b0);
    endtask

    task automatic do_inv(input logic [19:0] vpn);
        @(negedge clk);
        inv_valid = 1'b1;
        inv_vpn   = vpn;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic fill_all();
        for (int i = 0; i < 16; i++) fill_std(BASE + 20'(i));
    endtask

    task automatic t_reset();
        miss(BASE, "R1");
        miss(20'h00000, "R1");
        miss(20'hFFFFF, "R3");
    endtask

    task automatic t_basic();
        do_flush();
        fill_std(20'h00ABC);
        fill_std(20'h12345);
        fill_std(20'hFFFFF);
        hit_std(20'h12345, "R2");
        hit_std(20'h00ABC, "R2");
        hit_std(20'hFFFFF, "R2");
        miss(20'h12346, "R3");
        // request low: no hit even with a resident address on the bus
        @(negedge clk);
        lk_vaddr = {20'h12345, 12'h000};
        #2 chk(lk_hit == 1'b0, "R2", 64'(lk_hit), 64'd0);
    endtask

    task automatic t_capacity();
        do_flush();
        fill_all();
        for (int i = 0; i < 16; i++) hit_std(BASE + 20'(i), "R4");
    endtask

    task automatic t_saturate();
        do_flush();
        fill_all();
        fill_std(20'h77777);
        miss(BASE, "R7");
        hit_std(20'h77777, "R7");
        for (int i = 1; i < 16; i++) hit_std(BASE + 20'(i), "R7");
    endtask

    task automatic t_nru();
        do_flush();
        fill_all();
        for (int i = 0; i < 4; i++) hit_std(BASE + 20'(i), "R6");
        fill_std(20'h88888);
        miss(BASE + 20'd4, "R6");
        hit_std(20'h88888, "R6");
        fill_std(20'h99999);
        miss(BASE + 20'd5, "R6");
        hit_std(BASE + 20'd0, "R6");
        hit_std(BASE + 20'd6, "R6");
        hit_std(20'h99999, "R6");
    endtask

    task automatic t_overwrite();
        do_flush();
        fill_all();
        fill(BASE + 20'd3, 20'hCAFE1, 4'h6, 1'b0);
        probe(BASE + 20'd3, 1'b1, 20'hCAFE1, 4'h6, "R5");
        for (int i = 0; i < 16; i++)
            if (i != 3) hit_std(BASE + 20'(i), "R5");
    endtask

    task automatic t_inval();
        do_flush();
        fill_all();
        do_inv(BASE + 20'd7);
        miss(BASE + 20'd7, "R8");
        hit_std(BASE + 20'd6, "R8");
        hit_std(BASE + 20'd8, "R8");
        do_inv(20'h55555);
        fill_std(20'h44444);
        hit_std(20'h44444, "R8");
        miss(BASE + 20'd7, "R8");
        for (int i = 0; i < 16; i++)
            if (i != 7) hit_std(BASE + 20'(i), "R8");
    endtask

    task automatic t_flush();
        do_flush();
        fill_std(20'h00111);
        fill_std(20'h00222);
        do_flush();
        miss(20'h00111, "R9");
        miss(20'h00222, "R9");
        fill_std(20'h00333);
        hit_std(20'h00333, "R9");
    endtask

    task automatic t_flush_fill();
        do_flush();
        fill_std(20'h0AAAA);
        fill(20'h0BBBB, frm(20'h0BBBB), atr(20'h0BBBB), 1'b1);
        miss(20'h0BBBB, "R10");
        miss(20'h0AAAA, "R10");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_capacity();
        t_saturate();
        t_nru();
        t_overwrite();
        t_inval();
        t_flush();
        t_flush_fill();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule